// File: doc/BRIEF.md
# Hybrid Bus Integrity Monitor

This block watches a byte-wide backplane bus that carries both circuit-switched (isochronous) time slots and packet traffic, and raises error flags when the bus signals lose integrity. It runs on a fast local reference clock. The bus clock indication arrives as a plain input, and each of its rising edges marks one bus time slot. The byte, control bit and parity bit are checked in every slot. The isochronous indication is checked against its complement line in every slot outside the sync interval. The arbitration pair is compared in every reference cycle, so a broken arbitration line shows up at once. Two missing-pulse watchdogs guard the bus clock and the frame sync.

Every fault sets a sticky flag. A one-cycle event strobe marks each newly raised flag. If the isochronous pair keeps failing, the block enters a degraded mode. In that mode its slot-qualifier output lets packet logic use only the slots that coincide with sync. Both the flags and the degraded mode are cleared only by an explicit clear input.

Top module: `hbus_integrity_mon`

## Requirements
- R1: In every slot, the block samples `dataByte`, `ctrlBit` and `parityBit`. These ten bits must have odd parity (XOR of all ten equals 1). Otherwise `errFlags[0]` is set on the reference edge that detects the bus-clock rise.
- R2: In every slot where `syncInd` is low, equal values on `isoInd` and `isoIndN` set `errFlags[1]`. In a slot where `syncInd` is high, the pair is not checked.
- R3: `arbFault` is high in the same cycle in which `arbInd` equals `arbIndN`, with or without a bus-clock edge. `errFlags[2]` is set on the next reference edge.
- R4: If no bus-clock rise is seen, `errFlags[3]` is set on the (CLK_LIMIT+1)-th reference edge after the edge that sampled the last rise, and not earlier.
- R5: The sync timeout is SYNC_LIMIT = FRAME_SLOTS + FRAME_SLOTS/2 slots. `errFlags[4]` is set once SYNC_LIMIT slots have followed the last rising sync slot with no new rise, and not after SYNC_LIMIT-1.
- R6: Every flag stays set until `clearErr`. If the fault condition is still present during the clear cycle, the flag stays set.
- R7: `errEvent` pulses for one cycle, in the same cycle in which a flag first appears. A fault that only repeats an already set flag gives no pulse.
- R8: `degraded` rises after ISO_LIMIT consecutive checked slots with an isochronous pair mismatch. A checked slot with a good pair restarts the count. Sync slots neither add to the count nor reset it.
- R9: `degraded` stays high until `clearErr`, whatever the later slots carry.
- R10: `pktSlotOk` equals `syncInd | (!degraded & !isoInd)`.
- R11: After reset, `errFlags`, `errEvent` and `degraded` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearErr | input | 1 | Clears sticky flags and degraded mode |
| busClk | input | 1 | Bus clock indication, sampled by clk |
| syncInd | input | 1 | Frame sync indication, active high |
| dataByte | input | 8 | Bus data byte |
| ctrlBit | input | 1 | Control/data qualifier bit |
| parityBit | input | 1 | Odd parity over data and control |
| isoInd | input | 1 | Isochronous slot indication |
| isoIndN | input | 1 | Complement of isochronous indication |
| arbInd | input | 1 | Arbitration line |
| arbIndN | input | 1 | Complement of arbitration line |
| errFlags | output | 5 | Sticky flags: parity, iso pair, arb pair, bus clock, sync |
| errEvent | output | 1 | One-cycle strobe on a newly raised flag |
| arbFault | output | 1 | Immediate arbitration pair mismatch |
| degraded | output | 1 | Packet traffic limited to sync slots |
| pktSlotOk | output | 1 | Current slot may carry packet data |

## Verification
The bench sweeps all 1024 combinations of data, control and parity bits, so a parity tree with the wrong polarity or a missing bit is caught. It tries every isochronous pair value with and without sync, which catches a design that checks the pair during sync. It places the clock and sync watchdog checks one cycle and one slot on each side of the limit, so an off-by-one trip point is exposed. The degraded-mode sequence mixes good and sync slots into the mismatch run: a design that fails to restart the count on a good slot, or that lets a sync slot reset or advance it, enters degraded mode at the wrong slot.

// File: rtl/hbim_pkg.sv
package hbim_pkg;
  localparam int ERR_PAR  = 0;
  localparam int ERR_ISO  = 1;
  localparam int ERR_ARB  = 2;
  localparam int ERR_CLK  = 3;
  localparam int ERR_SYNC = 4;
  localparam int NUM_ERR  = 5;

  typedef struct packed {
    logic slotTick;
    logic clkTimeout;
    logic syncTimeout;
    logic clearReq;
  } ctrl_strobe_t;
endpackage

// File: rtl/hbim_ctrl.sv
module hbim_ctrl
  import hbim_pkg::*;
#(
  parameter int CLK_LIMIT  = 16,
  parameter int SYNC_LIMIT = 3645,
  parameter int ISO_LIMIT  = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busClk,
  input  logic         syncInd,
  input  logic         clearErr,
  input  logic         isoBad,
  output ctrl_strobe_t strobes,
  output logic         degraded
);
  localparam int CW = $clog2(CLK_LIMIT + 1);
  localparam int SW = $clog2(SYNC_LIMIT + 1);
  localparam int IW = $clog2(ISO_LIMIT + 1);

  logic          busClkQ;
  logic          syncQ;
  logic [CW-1:0] clkCnt;
  logic [SW-1:0] syncCnt;
  logic [IW-1:0] isoRun;
  logic          slotTick;
  logic          syncRise;
  logic          isoChecked;

  assign slotTick   = busClk & ~busClkQ;
  assign syncRise   = slotTick & syncInd & ~syncQ;
  assign isoChecked = slotTick & ~syncInd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busClkQ  <= 1'b0;
      syncQ    <= 1'b0;
      clkCnt   <= '0;
      syncCnt  <= '0;
      isoRun   <= '0;
      degraded <= 1'b0;
    end else begin
      busClkQ <= busClk;
      if (slotTick) syncQ <= syncInd;

      // bus clock watchdog, in reference cycles
      if (slotTick) clkCnt <= '0;
      else if (clkCnt != CW'(CLK_LIMIT)) clkCnt <= clkCnt + 1'b1;

      // frame sync watchdog, in bus slots
      if (syncRise) syncCnt <= '0;
      else if (slotTick && syncCnt != SW'(SYNC_LIMIT)) syncCnt <= syncCnt + 1'b1;

      // consecutive isochronous pair failures
      if (clearErr) begin
        isoRun   <= '0;
        degraded <= 1'b0;
      end else if (isoChecked) begin
        if (isoBad) begin
          if (isoRun != IW'(ISO_LIMIT)) isoRun <= isoRun + 1'b1;
          if (isoRun == IW'(ISO_LIMIT - 1)) degraded <= 1'b1;
        end else begin
          isoRun <= '0;
        end
      end
    end
  end

  always_comb begin
    strobes.slotTick    = slotTick;
    strobes.clkTimeout  = (clkCnt == CW'(CLK_LIMIT));
    strobes.syncTimeout = (syncCnt == SW'(SYNC_LIMIT));
    strobes.clearReq    = clearErr;
  end

  assert_degraded_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (degraded && !clearErr) |=> degraded)
    else $error("degraded dropped without clear");
endmodule

// File: rtl/hbim_datapath.sv
module hbim_datapath
  import hbim_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrl_strobe_t       strobes,
  input  logic               syncInd,
  input  logic [7:0]         dataByte,
  input  logic               ctrlBit,
  input  logic               parityBit,
  input  logic               isoInd,
  input  logic               isoIndN,
  input  logic               arbInd,
  input  logic               arbIndN,
  output logic               isoBad,
  output logic               arbFault,
  output logic [NUM_ERR-1:0] errFlags,
  output logic               errEvent
);
  logic               parBad;
  logic [NUM_ERR-1:0] detect;
  logic [NUM_ERR-1:0] flagNext;
  logic [NUM_ERR-1:0] fresh;

  assign parBad   = ~^{dataByte, ctrlBit, parityBit};
  assign isoBad   = (isoInd == isoIndN);
  assign arbFault = (arbInd == arbIndN);

  always_comb begin
    detect           = '0;
    detect[ERR_PAR]  = strobes.slotTick & parBad;
    detect[ERR_ISO]  = strobes.slotTick & ~syncInd & isoBad;
    detect[ERR_ARB]  = arbFault;
    detect[ERR_CLK]  = strobes.clkTimeout;
    detect[ERR_SYNC] = strobes.syncTimeout;
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : gFlag
    assign flagNext[g] = strobes.clearReq ? detect[g] : (errFlags[g] | detect[g]);
    assign fresh[g]    = detect[g] & (strobes.clearReq | ~errFlags[g]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlags <= '0;
      errEvent <= 1'b0;
    end else begin
      errFlags <= flagNext;
      errEvent <= |fresh;
    end
  end

  assert_arb_flag_R3: assert property (@(posedge clk) disable iff (!rstN)
    arbFault |=> errFlags[ERR_ARB])
    else $error("arb mismatch not flagged");

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearReq |=> ((errFlags & $past(errFlags)) == $past(errFlags)))
    else $error("flag lost without clear");

  assert_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    errEvent |-> (errFlags != '0))
    else $error("event without flag");

  assert_iso_skip_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.slotTick && syncInd && !strobes.clearReq && !errFlags[ERR_ISO])
      |=> !errFlags[ERR_ISO])
    else $error("iso pair checked in sync slot");
endmodule

// File: rtl/hbus_integrity_mon.sv
module hbus_integrity_mon
  import hbim_pkg::*;
#(
  parameter int CLK_LIMIT   = 16,
  parameter int FRAME_SLOTS = 2430,
  parameter int ISO_LIMIT   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clearErr,
  input  logic       busClk,
  input  logic       syncInd,
  input  logic [7:0] dataByte,
  input  logic       ctrlBit,
  input  logic       parityBit,
  input  logic       isoInd,
  input  logic       isoIndN,
  input  logic       arbInd,
  input  logic       arbIndN,
  output logic [4:0] errFlags,
  output logic       errEvent,
  output logic       arbFault,
  output logic       degraded,
  output logic       pktSlotOk
);
  localparam int SYNC_LIMIT = FRAME_SLOTS + FRAME_SLOTS / 2;

  ctrl_strobe_t strobes;
  logic         isoBad;

  hbim_ctrl #(
    .CLK_LIMIT (CLK_LIMIT),
    .SYNC_LIMIT(SYNC_LIMIT),
    .ISO_LIMIT (ISO_LIMIT)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busClk  (busClk),
    .syncInd (syncInd),
    .clearErr(clearErr),
    .isoBad  (isoBad),
    .strobes (strobes),
    .degraded(degraded)
  );

  hbim_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .syncInd  (syncInd),
    .dataByte (dataByte),
    .ctrlBit  (ctrlBit),
    .parityBit(parityBit),
    .isoInd   (isoInd),
    .isoIndN  (isoIndN),
    .arbInd   (arbInd),
    .arbIndN  (arbIndN),
    .isoBad   (isoBad),
    .arbFault (arbFault),
    .errFlags (errFlags),
    .errEvent (errEvent)
  );

  assign pktSlotOk = syncInd | (~degraded & ~isoInd);
endmodule

// File: tb/hbus_integrity_mon_tb.sv
module hbus_integrity_mon_tb;
  localparam int CLK_LIMIT = 8;
  localparam int FRAME     = 8;
  localparam int SYNC_LIM  = FRAME + FRAME / 2;
  localparam int ISO_LIM   = 3;

  logic clk = 0, rstN = 0, clearErr = 0, busClk = 0, syncInd = 0;
  logic [7:0] dataByte = 0;
  logic ctrlBit = 0, parityBit = 1, isoInd = 0, isoIndN = 1, arbInd = 0, arbIndN = 1;
  logic [4:0] errFlags;
  logic errEvent, arbFault, degraded, pktSlotOk;
  logic [4:0] sFlags;
  logic sEvent;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  hbus_integrity_mon #(.CLK_LIMIT(CLK_LIMIT), .FRAME_SLOTS(FRAME), .ISO_LIMIT(ISO_LIM)) u_dut (
    .clk(clk), .rstN(rstN), .clearErr(clearErr), .busClk(busClk), .syncInd(syncInd),
    .dataByte(dataByte), .ctrlBit(ctrlBit), .parityBit(parityBit), .isoInd(isoInd),
    .isoIndN(isoIndN), .arbInd(arbInd), .arbIndN(arbIndN), .errFlags(errFlags),
    .errEvent(errEvent), .arbFault(arbFault), .degraded(degraded), .pktSlotOk(pktSlotOk));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one bus slot: called and returns just after a falling edge
  task automatic slot(logic [7:0] d, logic c, logic p, logic iso, logic isoN, logic s);
    dataByte = d; ctrlBit = c; parityBit = p; isoInd = iso; isoIndN = isoN; syncInd = s;
    busClk = 1;
    @(negedge clk);
    sFlags = errFlags; sEvent = errEvent;
    busClk = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic goodSlot(logic s);
    slot(8'h00, 1'b0, 1'b1, 1'b0, 1'b1, s);
  endtask

  task automatic badIsoSlot(logic s);
    slot(8'h00, 1'b0, 1'b1, 1'b1, 1'b1, s);
  endtask

  task automatic doClear();
    clearErr = 1;
    @(negedge clk);
    clearErr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    chk("R11 flags", errFlags, 0);
    chk("R11 event", errEvent, 0);
    chk("R11 degraded", degraded, 0);

    // R1: exhaustive parity sweep; sync every fourth slot keeps the watchdog quiet
    for (int i = 0; i < 1024; i++) begin
      logic [9:0] v;
      logic exp;
      v = 10'(i);
      exp = ~^v;
      slot(v[7:0], v[8], v[9], 1'b0, 1'b1, (i % 4) == 0);
      chk("R1 parity flag", sFlags, {4'b0, exp});
      chk("R7 event on parity", sEvent, exp);
      doClear();
    end

    // R6 and R7: sticky flag, no repeat event
    slot(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6 parity set", sFlags[0], 1);
    chk("R7 event first", sEvent, 1);
    slot(8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R7 no event on repeat", sEvent, 0);
    goodSlot(1'b0);
    chk("R6 held over good slot", sFlags[0], 1);
    doClear();
    chk("R6 cleared", errFlags, 0);

    // R2: all isochronous pair values, with and without sync
    for (int i = 0; i < 8; i++) begin
      logic [2:0] b;
      b = 3'(i);
      doClear();
      slot(8'h00, 1'b0, 1'b1, b[0], b[1], b[2]);
      chk("R2 iso flag", sFlags, {3'b0, (b[0] == b[1]) & ~b[2], 1'b0});
    end
    goodSlot(1'b0);
    doClear();

    // R8: run counting with restart and sync slots in between
    badIsoSlot(1'b0); badIsoSlot(1'b0); goodSlot(1'b0);
    badIsoSlot(1'b0); badIsoSlot(1'b0);
    chk("R8 not yet degraded", degraded, 0);
    badIsoSlot(1'b1);
    chk("R8 sync slot not counted", degraded, 0);
    badIsoSlot(1'b0);
    chk("R8 degraded at limit", degraded, 1);

    // R10 in degraded mode
    syncInd = 1; isoInd = 0; isoIndN = 1; #1;
    chk("R10 degraded sync slot ok", pktSlotOk, 1);
    syncInd = 0; #1;
    chk("R10 degraded free slot blocked", pktSlotOk, 0);
    @(negedge clk);

    // R9: held over good slots until clear
    goodSlot(1'b0); goodSlot(1'b0);
    chk("R9 degraded held", degraded, 1);
    doClear();
    chk("R9 degraded cleared", degraded, 0);
    syncInd = 0; isoInd = 0; isoIndN = 1; #1;
    chk("R10 normal free slot", pktSlotOk, 1);
    isoInd = 1; isoIndN = 0; #1;
    chk("R10 normal iso slot", pktSlotOk, 0);
    syncInd = 1; #1;
    chk("R10 normal sync slot", pktSlotOk, 1);
    syncInd = 0; isoInd = 0; isoIndN = 1;
    @(negedge clk);
    goodSlot(1'b1);
    doClear();

    // R3: arbitration pair, no bus clock edge involved
    chk("R3 no fault when complementary", arbFault, 0);
    arbInd = 1; arbIndN = 1; #1;
    chk("R3 immediate fault", arbFault, 1);
    @(negedge clk);
    chk("R3 flag next edge", errFlags, 5'b00100);
    chk("R7 event on arb", errEvent, 1);
    arbInd = 0; arbIndN = 0;
    @(negedge clk);
    arbInd = 0; arbIndN = 1;
    @(negedge clk);
    chk("R3 flag sticky", errFlags[2], 1);
    doClear();
    chk("R3 cleared", errFlags, 0);

    // R4: bus clock watchdog boundary
    goodSlot(1'b0);
    repeat (6) @(negedge clk);
    chk("R4 not before limit", errFlags[3], 0);
    @(negedge clk);
    chk("R4 flagged at limit", errFlags[3], 1);
    doClear();
    chk("R6 clear with fault present", errFlags[3], 1);
    goodSlot(1'b0);
    doClear();
    chk("R4 recovered", errFlags, 0);

    // R5: sync watchdog boundary
    goodSlot(1'b1);
    for (int k = 0; k < SYNC_LIM - 1; k++) goodSlot(1'b0);
    chk("R5 not before limit", errFlags[4], 0);
    goodSlot(1'b0);
    chk("R5 flagged at limit", errFlags[4], 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule